// File: doc/BRIEF.md
# Valid-Ready Word Memory Target

This block is a memory target for a simple request bus with one outstanding request, as used by a small 32-bit processor. The requester raises `req_valid` together with an address, write data, a 4-bit byte-lane strobe and a flag that marks instruction fetches. The target answers with `req_ready` in the completing cycle. For reads, it also returns a 32-bit word. An all-zero strobe is a read. A non-zero strobe is a write, and it may touch a whole word, either half-word or a single byte.

Low addresses map to an internal word array. One fixed address is a character output port: a write there places the low data byte on `out_byte` and pulses `out_stb` for one cycle. Every other address is still acknowledged, but it raises a sticky out-of-range flag. Reads from such addresses return zero.

A built-in monitor watches the requester. It raises a sticky protocol flag in three cases:
- the requester drops valid before ready;
- the requester changes a request field while waiting;
- the requester uses a strobe pattern outside the legal set.

A parameter selects between two acknowledge modes:
- a zero-wait mode, in which ready follows valid combinationally;
- a mode with a fixed number of wait cycles.

Top module: `vr_mem_target`

## Requirements
- R1: `req_ready` is never high without `req_valid`. A transfer completes in the cycle where both are high.
- R2: With `WAIT_CYCLES` = 0, `req_ready` is high in the same cycle that `req_valid` is high, with no wait state.
- R3: With `WAIT_CYCLES` = N > 0, `req_ready` first rises N cycles after `req_valid` rises, provided valid is held.
- R4: A strobe of 4'b0000 is a read. In the ready cycle, `rsp_rdata` carries the addressed word.
- R5: In a write, strobe bit n enables data bits [8n+7:8n] of the addressed word. The other bytes keep their old value.
- R6: The legal strobes are 0000, 1111, 1100, 0011, 1000, 0100, 0010 and 0001. A completed transfer with any other strobe sets `err_proto` and writes nothing.
- R7: `err_proto` sets and stays set if, while the requester is waiting for ready, valid drops or any of address, write data, strobe or fetch flag changes.
- R8: `last_fetch` takes the fetch flag of the most recent completed read. Writes leave it unchanged.
- R9: An address below `MEM_WORDS`*4 selects the array word given by address bits [log2(MEM_WORDS)+1:2]. The highest word is reachable.
- R10: A legal write to `OUT_ADDR` leaves the array untouched. It drives `out_byte` with write-data bits [7:0], and `out_stb` is high for exactly the cycle after the handshake.
- R11: Any other address is acknowledged like an array access. A read from it returns 32'h0. In both cases `err_oob` sets and stays set.
- R12: An active-low synchronous reset clears `req_ready`, `err_proto`, `err_oob`, `last_fetch`, `out_stb` and the wait counter. Array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Transfer acknowledge |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane strobe, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch |
| rsp_rdata | output | 32 | Read data |
| out_byte | output | 8 | Character output data |
| out_stb | output | 1 | One-cycle character output strobe |
| err_proto | output | 1 | Sticky protocol violation flag |
| err_oob | output | 1 | Sticky out-of-range flag |
| last_fetch | output | 1 | Fetch flag of the most recent read |

## Verification
The assertions check the following on every cycle:
- ready never appears without valid;
- zero-wait acknowledge;
- the stickiness of both error flags;
- that a dropped valid or an illegal strobe raises `err_proto`;
- that `out_stb` only follows a write to the output port;
- that `last_fetch` tracks completed reads.

Other behaviour can only be shown by the bench's scenarios, because it depends on data flow through the array:
- the byte-lane merge results;
- the contents of the last array word;
- a rejected write leaving memory unchanged;
- reads beyond the array returning zero;
- memory surviving reset;
- the exact wait-cycle count.

// File: rtl/vr_mem_target.sv
module vr_mem_target #(
  parameter int          WAIT_CYCLES = 0,
  parameter int          MEM_WORDS   = 1024,
  parameter logic [31:0] OUT_ADDR    = 32'h1000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_strb,
  input  logic        req_fetch,
  output logic [31:0] rsp_rdata,
  output logic [7:0]  out_byte,
  output logic        out_stb,
  output logic        err_proto,
  output logic        err_oob,
  output logic        last_fetch
);
  localparam int          IDX_W     = $clog2(MEM_WORDS);
  localparam int          CNT_W     = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
  localparam logic [31:0] MEM_BYTES = 32'(MEM_WORDS * 4);

  logic [31:0]      mem [MEM_WORDS];
  logic [CNT_W-1:0] wcnt;
  logic             busy_q;
  logic [31:0]      addr_q, wdata_q;
  logic [3:0]       strb_q;
  logic             fetch_q;

  logic             in_array, to_port, is_read, strb_ok, fire, changed;
  logic [IDX_W-1:0] idx;
  logic             unused_lowbits;

  assign unused_lowbits = ^req_addr[1:0];
  assign idx      = req_addr[IDX_W+1:2];
  assign in_array = req_addr < MEM_BYTES;
  assign is_read  = req_strb == 4'b0000;
  assign to_port  = !is_read && req_addr == OUT_ADDR;
  assign req_ready = rst_n && req_valid && wcnt == CNT_W'(WAIT_CYCLES);
  assign fire     = req_valid && req_ready;
  assign rsp_rdata = in_array ? mem[idx] : 32'h0;
  assign changed  = req_addr != addr_q || req_wdata != wdata_q ||
                    req_strb != strb_q || req_fetch != fetch_q;

  always_comb begin
    case (req_strb)
      4'b0000, 4'b1111, 4'b1100, 4'b0011,
      4'b1000, 4'b0100, 4'b0010, 4'b0001: strb_ok = 1'b1;
      default:                            strb_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (fire && !is_read && strb_ok && in_array) begin
      for (int b = 0; b < 4; b++)
        if (req_strb[b]) mem[idx][8*b +: 8] <= req_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= req_addr;
    wdata_q <= req_wdata;
    strb_q  <= req_strb;
    fetch_q <= req_fetch;
    if (!rst_n) begin
      wcnt       <= '0;
      busy_q     <= 1'b0;
      out_stb    <= 1'b0;
      out_byte   <= 8'h0;
      err_proto  <= 1'b0;
      err_oob    <= 1'b0;
      last_fetch <= 1'b0;
    end else begin
      busy_q  <= req_valid && !req_ready;
      out_stb <= 1'b0;
      if (!req_valid || fire) wcnt <= '0;
      else                    wcnt <= wcnt + 1'b1;
      if (busy_q && (!req_valid || changed)) err_proto <= 1'b1;
      if (fire) begin
        if (!strb_ok) err_proto <= 1'b1;
        if (is_read)  last_fetch <= req_fetch;
        if (!in_array && !to_port) err_oob <= 1'b1;
        if (to_port && strb_ok) begin
          out_stb  <= 1'b1;
          out_byte <= req_wdata[7:0];
        end
      end
    end
  end
endmodule

module vr_mem_target_chk #(
  parameter int          WAIT_CYCLES = 0,
  parameter logic [31:0] OUT_ADDR    = 32'h1000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [3:0]  req_strb,
  input logic        req_fetch,
  input logic        out_stb,
  input logic        err_proto,
  input logic        err_oob,
  input logic        last_fetch
);
  logic strb_bad;
  always_comb begin
    case (req_strb)
      4'b0000, 4'b1111, 4'b1100, 4'b0011,
      4'b1000, 4'b0100, 4'b0010, 4'b0001: strb_bad = 1'b0;
      default:                            strb_bad = 1'b1;
    endcase
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid); // R1
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (WAIT_CYCLES == 0 && req_valid) |-> req_ready); // R2
  AST_BAD_STRB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && strb_bad) |=> err_proto); // R6
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && !$past(req_ready) && !req_valid) |=> err_proto); // R7
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto |=> err_proto); // R7
  AST_FETCH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_strb == 4'b0000) |=> last_fetch == $past(req_fetch)); // R8
  AST_PORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> $past(req_valid && req_ready && req_addr == OUT_ADDR && req_strb != 4'b0000)); // R10
  AST_OOB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_oob |=> err_oob); // R11
endmodule

bind vr_mem_target vr_mem_target_chk #(.WAIT_CYCLES(WAIT_CYCLES), .OUT_ADDR(OUT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_strb(req_strb), .req_fetch(req_fetch),
  .out_stb(out_stb), .err_proto(err_proto), .err_oob(err_oob), .last_fetch(last_fetch));

// File: tb/vr_mem_target_test.sv
`timescale 1ns/1ps
module vr_mem_target_test;
  localparam logic [31:0] PORT = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, valid_w = 1'b0, fetch = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0]  strb = '0;
  logic ready, ready_w, out_stb, out_stb_w, err_proto, err_proto_w;
  logic err_oob, err_oob_w, last_fetch, last_fetch_w;
  logic [31:0] rdata, rdata_w;
  logic [7:0]  out_byte, out_byte_w;
  logic        got_rdy;
  logic [31:0] got_rd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vr_mem_target #(.WAIT_CYCLES(0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(valid), .req_ready(ready), .req_addr(addr),
    .req_wdata(wdata), .req_strb(strb), .req_fetch(fetch), .rsp_rdata(rdata),
    .out_byte(out_byte), .out_stb(out_stb), .err_proto(err_proto), .err_oob(err_oob),
    .last_fetch(last_fetch));

  vr_mem_target #(.WAIT_CYCLES(2)) uut_w (
    .clk(clk), .rst_n(rst_n), .req_valid(valid_w), .req_ready(ready_w), .req_addr(addr),
    .req_wdata(wdata), .req_strb(strb), .req_fetch(fetch), .rsp_rdata(rdata_w),
    .out_byte(out_byte_w), .out_stb(out_stb_w), .err_proto(err_proto_w), .err_oob(err_oob_w),
    .last_fetch(last_fetch_w));

  // {addr, wdata, strb, fetch, expected read data (reads only)}
  localparam int NV = 11;
  localparam logic [100:0] VEC [NV] = '{
    {32'h0000_0010, 32'hAABB_CCDD, 4'b1111, 1'b0, 32'h0},
    {32'h0000_0010, 32'h0,         4'b0000, 1'b0, 32'hAABB_CCDD},
    {32'h0000_0010, 32'h1122_3344, 4'b0011, 1'b0, 32'h0},
    {32'h0000_0010, 32'h0,         4'b0000, 1'b1, 32'hAABB_3344},
    {32'h0000_0010, 32'h5566_7788, 4'b1000, 1'b0, 32'h0},
    {32'h0000_0010, 32'h9999_9999, 4'b0100, 1'b0, 32'h0},
    {32'h0000_0010, 32'h0000_EE00, 4'b0010, 1'b0, 32'h0},
    {32'h0000_0010, 32'h0000_00F0, 4'b0001, 1'b0, 32'h0},
    {32'h0000_0010, 32'h0,         4'b0000, 1'b0, 32'h5599_EEF0},
    {32'h0000_0FFC, 32'hCAFE_F00D, 4'b1111, 1'b0, 32'h0},
    {32'h0000_0FFC, 32'h0,         4'b0000, 1'b0, 32'hCAFE_F00D}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, input logic f);
    @(negedge clk);
    addr = a; wdata = d; strb = s; fetch = f; valid = 1'b1;
    #1 got_rdy = ready; got_rd = rdata;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    valid = 1'b1; #1;
    chk("R12 ready held low in reset", {31'b0, ready}, 32'h0);
    valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 err_proto after reset", {31'b0, err_proto}, 32'h0);
    chk("R12 err_oob after reset", {31'b0, err_oob}, 32'h0);
    chk("R12 out_stb after reset", {31'b0, out_stb}, 32'h0);
    chk("R12 last_fetch after reset", {31'b0, last_fetch}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][100:69], VEC[i][68:37], VEC[i][36:33], VEC[i][32]);
      chk($sformatf("R2 vector %0d zero-wait ready", i), {31'b0, got_rdy}, 32'h1);
      if (VEC[i][36:33] == 4'b0000)
        chk($sformatf("R4 R5 R9 vector %0d read data", i), got_rd, VEC[i][31:0]);
    end

    xfer(32'h10, 32'h0, 4'b0000, 1'b1);
    chk("R8 fetch read recorded", {31'b0, last_fetch}, 32'h1);
    xfer(32'hFFC, 32'hCAFE_F00D, 4'b1111, 1'b0);
    chk("R8 write leaves last_fetch", {31'b0, last_fetch}, 32'h1);

    xfer(PORT, 32'h1234_5641, 4'b0001, 1'b0);
    chk("R10 port ack", {31'b0, got_rdy}, 32'h1);
    chk("R10 out_stb pulse", {31'b0, out_stb}, 32'h1);
    chk("R10 out_byte", {24'b0, out_byte}, 32'h41);
    chk("R10 no oob on port", {31'b0, err_oob}, 32'h0);
    @(negedge clk);
    chk("R10 out_stb one cycle", {31'b0, out_stb}, 32'h0);
    xfer(32'h10, 32'h0, 4'b0000, 1'b0);
    chk("R10 array untouched by port write", got_rd, 32'h5599_EEF0);

    xfer(32'h10, 32'hFFFF_FFFF, 4'b0101, 1'b0);
    chk("R6 illegal strobe acked", {31'b0, got_rdy}, 32'h1);
    chk("R6 illegal strobe flagged", {31'b0, err_proto}, 32'h1);
    xfer(32'h10, 32'h0, 4'b0000, 1'b0);
    chk("R6 illegal write dropped", got_rd, 32'h5599_EEF0);

    do_reset();
    chk("R12 reset clears err_proto", {31'b0, err_proto}, 32'h0);
    xfer(32'h10, 32'h0, 4'b0000, 1'b0);
    chk("R12 memory kept over reset", got_rd, 32'h5599_EEF0);

    xfer(32'h0000_1000, 32'h7777_7777, 4'b1111, 1'b0);
    chk("R11 oob write acked", {31'b0, got_rdy}, 32'h1);
    chk("R11 oob write flagged", {31'b0, err_oob}, 32'h1);
    xfer(32'hFFC, 32'h0, 4'b0000, 1'b0);
    chk("R9 last word unaffected by oob write", got_rd, 32'hCAFE_F00D);
    do_reset();
    chk("R12 reset clears err_oob", {31'b0, err_oob}, 32'h0);
    xfer(32'h2000_0000, 32'h0, 4'b0000, 1'b0);
    chk("R11 oob read returns zero", got_rd, 32'h0);
    chk("R11 oob read flagged", {31'b0, err_oob}, 32'h1);

    @(negedge clk);
    addr = 32'h0; wdata = 32'h0BAD_BEEF; strb = 4'b1111; fetch = 1'b0; valid_w = 1'b1;
    #1 chk("R3 wait cycle 0", {31'b0, ready_w}, 32'h0);
    @(negedge clk); #1 chk("R3 wait cycle 1", {31'b0, ready_w}, 32'h0);
    @(negedge clk); #1 chk("R3 ready after two waits", {31'b0, ready_w}, 32'h1);
    @(negedge clk); valid_w = 1'b0; strb = 4'b0000;
    @(negedge clk); valid_w = 1'b1;
    @(negedge clk); @(negedge clk);
    #1 chk("R3 R4 wait-mode read ready", {31'b0, ready_w}, 32'h1);
    chk("R3 R4 wait-mode read data", rdata_w, 32'h0BAD_BEEF);
    @(negedge clk); valid_w = 1'b0;
    chk("R7 clean handshake no error", {31'b0, err_proto_w}, 32'h0);

    @(negedge clk); valid_w = 1'b1;
    @(negedge clk); valid_w = 1'b0;
    @(negedge clk);
    chk("R7 valid dropped before ready", {31'b0, err_proto_w}, 32'h1);

    do_reset();
    @(negedge clk); addr = 32'h0; valid_w = 1'b1;
    @(negedge clk); addr = 32'h4;
    @(negedge clk);
    chk("R7 address changed while waiting", {31'b0, err_proto_w}, 32'h1);
    valid_w = 1'b0;
    @(negedge clk);
    chk("R1 ready low without valid", {31'b0, ready_w}, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule